// File: doc/BRIEF.md
# Core-Local Interrupt Timer

This block is the timer of a per-core interrupt controller. A 32-bit count runs down on ticks from a power-of-two prescaler that divides the base clock. Software programs three things through a small register port:

- a timer entry that holds the interrupt vector, a mask bit and a one-shot/periodic mode bit;
- a divide-configuration code that picks the prescaler ratio;
- an initial count.

The current count can be read back at any time. When the count expires and the entry is unmasked, the block raises `irq_valid` for exactly one clock, with the programmed vector on `irq_vector`.

A small state machine controls the run state:

- `ST_IDLE`: no count is armed.
- `ST_RUN`: counting.
- `ST_DONE`: a one-shot count has finished.

The transitions are:

- *arm*: `ST_IDLE`/`ST_DONE` to `ST_RUN`, on a non-zero initial-count write.
- *reload*: `ST_RUN` to `ST_RUN`, on a periodic expiry.
- *finish*: `ST_RUN` to `ST_DONE`, on a one-shot expiry.
- *disarm*: any state to `ST_IDLE`, on an initial-count write of zero.

Scaled ticks are counted from the cycle in which the initial count was loaded. Tick k falls k·2^s base cycles after the load edge, where s is the active shift.

Top module: `core_irq_timer`

## Requirements
- R1: After reset the timer entry reads 0x0001_0000 (masked, vector 0, one-shot), and the divide, initial-count and current-count registers read 0. The active shift is 0, so a tick occurs on every clock until a divide code is written.
- R2: The register addresses are 0 = timer entry, 1 = divide configuration, 2 = initial count, 3 = current count (read-only). The timer entry holds the vector in bits 7:0, the mask in bit 16 and periodic mode in bit 17. The divide register uses bits 0, 1 and 3: the code {b3,b1,b0} = 0..6 selects shift 1..7 (divide by 2..128), and code 7 selects shift 0 (divide by 1).
- R3: In one-shot mode with initial count N > 0, exactly one expiry occurs, (N+1)·2^s clocks after the load edge. No further expiry follows.
- R4: In one-shot mode the current count reads N minus the elapsed ticks until expiry, and 0 from expiry onward.
- R5: In periodic mode with N > 0, expiries occur every (N+1)·2^s clocks, counted from the load edge.
- R6: In periodic mode the current count reads N − (elapsed ticks mod (N+1)).
- R7: An initial count of 0 arms nothing in either mode. No expiry occurs and the current count reads 0.
- R8: While the mask bit is set, expiries raise no interrupt, but counting and reloading continue.
- R9: A write to the initial count loads the new value and restarts tick counting from that edge. If the write lands in an expiry cycle, the write wins and no interrupt is raised.
- R10: A divide-code write does not restart the count or move the load time. The new shift takes effect at the next tick boundary, or at once when no count is running.
- R11: `irq_valid` is high for one clock per expiry and carries the vector in force at that expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Combinational read data |
| irq_valid | output | 1 | One-clock expiry interrupt request |
| irq_vector | output | 8 | Vector that goes with `irq_valid` |

## Verification
The bench brings two functions into the same cycle: a periodic expiry and a software reload of the initial count. A count of 4 is loaded, and a new count is written so that its write edge coincides with the fifth tick, where the expiry is due. The result passes only if no interrupt appears on that edge, the current count reads the new value right after it, and the next expiries land at the spacing of the new count measured from the write edge.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;
    localparam int VEC_W        = 8;
    localparam int SH_W         = 3;
    localparam int PRE_W        = 7;
    localparam int LVT_MASK_BIT = 16;
    localparam int LVT_PER_BIT  = 17;

    localparam logic [1:0] A_LVT  = 2'd0;
    localparam logic [1:0] A_DIV  = 2'd1;
    localparam logic [1:0] A_INIT = 2'd2;
    localparam logic [1:0] A_CUR  = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } tstate_e;

    typedef struct packed {
        logic             periodic;
        logic             mask;
        logic [VEC_W-1:0] vec;
    } lvt_t;

    // code 0..6 -> shift 1..7, code 7 -> shift 0
    function automatic logic [SH_W-1:0] div_to_shift(input logic [2:0] code);
        return code + 3'd1;
    endfunction
endpackage

// File: rtl/ltmr_regs.sv
module ltmr_regs
    import ltmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    input  logic [CNT_W-1:0] cur_cnt,
    output lvt_t             lvt,
    output logic [2:0]       div_code,
    output logic [CNT_W-1:0] init_val,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             div_wr
);
    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[CNT_W-1:LVT_PER_BIT+1],
                              wr_data[LVT_MASK_BIT-1:VEC_W], wr_data[2]};

    assign load     = wr_en && (wr_addr == A_INIT);
    assign load_val = wr_data;
    assign div_wr   = wr_en && (wr_addr == A_DIV);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvt      <= '{periodic: 1'b0, mask: 1'b1, vec: '0};
            div_code <= '0;
            init_val <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_LVT: begin
                    lvt.vec      <= wr_data[VEC_W-1:0];
                    lvt.mask     <= wr_data[LVT_MASK_BIT];
                    lvt.periodic <= wr_data[LVT_PER_BIT];
                end
                A_DIV:   div_code <= {wr_data[3], wr_data[1:0]};
                A_INIT:  init_val <= wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_LVT: begin
                rd_data[VEC_W-1:0]   = lvt.vec;
                rd_data[LVT_MASK_BIT] = lvt.mask;
                rd_data[LVT_PER_BIT]  = lvt.periodic;
            end
            A_DIV: begin
                rd_data[1:0] = div_code[1:0];
                rd_data[3]   = div_code[2];
            end
            A_INIT:  rd_data = init_val;
            default: rd_data = cur_cnt;
        endcase
    end
endmodule

// File: rtl/ltmr_prescale.sv
module ltmr_prescale
    import ltmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       running,
    input  logic       load,
    input  logic       div_wr,
    input  logic [2:0] div_code,
    output logic       tick
);
    logic             cfg_seen;
    logic [SH_W-1:0]  pend_sh;
    logic [SH_W-1:0]  act_sh;
    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] msk;
    logic             apply;

    assign pend_sh = cfg_seen ? div_to_shift(div_code) : '0;

    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            msk[i] = (i < int'(act_sh));
        end
    end

    assign tick  = running && !load && ((pre & msk) == msk);
    assign apply = tick || load || !running;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_seen <= 1'b0;
            act_sh   <= '0;
            pre      <= '0;
        end else begin
            if (div_wr) cfg_seen <= 1'b1;
            if (apply)  act_sh   <= pend_sh;
            if (load || !running) pre <= '0;
            else                  pre <= pre + 1'b1;
        end
    end

    // R10
    shift_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_sh) |-> $past(apply));
endmodule

// File: rtl/ltmr_core.sv
module ltmr_core
    import ltmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] init_val,
    input  lvt_t             lvt,
    output logic             running,
    output logic [CNT_W-1:0] cur_cnt,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vector
);
    tstate_e st, st_nxt;
    logic    expire;

    assign running = (st == ST_RUN);
    assign expire  = running && tick && (cur_cnt == '0);

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: ;
            ST_RUN:  if (expire && !lvt.periodic) st_nxt = ST_DONE;
            ST_DONE: ;
            default: st_nxt = ST_IDLE;
        endcase
        if (load) st_nxt = (load_val == '0) ? ST_IDLE : ST_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_cnt    <= '0;
            irq_valid  <= 1'b0;
            irq_vector <= '0;
        end else begin
            irq_valid <= 1'b0;
            if (load) begin
                cur_cnt <= load_val;
            end else if (expire) begin
                irq_valid  <= !lvt.mask;
                irq_vector <= lvt.vec;
                cur_cnt    <= lvt.periodic ? init_val : '0;
            end else if (running && tick) begin
                cur_cnt <= cur_cnt - 1'b1;
            end
        end
    end

    // R11
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |=> !irq_valid);
    // R8
    masked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !$past(lvt.mask));
    // R4
    done_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE) |-> (cur_cnt == '0));
    // R6
    cur_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN) |-> (cur_cnt <= init_val));
    // R9
    load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ((cur_cnt == $past(load_val)) && !irq_valid));
endmodule

// File: rtl/core_irq_timer.sv
module core_irq_timer
    import ltmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vector
);
    lvt_t             lvt;
    logic [2:0]       div_code;
    logic [CNT_W-1:0] init_val, load_val, cur_cnt;
    logic             load, div_wr, tick, running;

    ltmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cur_cnt(cur_cnt), .lvt(lvt), .div_code(div_code),
        .init_val(init_val), .load(load), .load_val(load_val), .div_wr(div_wr)
    );

    ltmr_prescale u_pre (
        .clk(clk), .rst_n(rst_n), .running(running), .load(load),
        .div_wr(div_wr), .div_code(div_code), .tick(tick)
    );

    ltmr_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
        .load_val(load_val), .init_val(init_val), .lvt(lvt),
        .running(running), .cur_cnt(cur_cnt), .irq_valid(irq_valid),
        .irq_vector(irq_vector)
    );
endmodule

// File: tb/tb_core_irq_timer.sv
module tb_core_irq_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    int exp_cyc[$];
    logic [7:0] exp_vec[$];

    core_irq_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic expect_irq(input int at, input logic [7:0] v);
        exp_cyc.push_back(at);
        exp_vec.push_back(v);
    endtask

    // monitor: pops the scoreboard on each interrupt pulse
    always @(negedge clk) begin
        if (rst_n && irq_valid) begin
            if (exp_cyc.size() == 0) begin
                check("R3/R5/R7/R8/R9 unexpected irq at cycle", 32'(cyc), 32'hFFFF_FFFF);
            end else begin
                check("R3/R5/R9 irq cycle", 32'(cyc), 32'(exp_cyc.pop_front()));
                check("R11 irq vector", 32'(irq_vector), 32'(exp_vec.pop_front()));
            end
        end
    end

    // called at a negedge; the write lands on the next posedge
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        check(tag, rd_data, exp);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic queue_empty(input string tag);
        check(tag, 32'(exp_cyc.size()), 32'd0);
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        int l, l2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_chk("R1 lvt reset", 2'd0, 32'h0001_0000);
        rd_chk("R1 divide reset", 2'd1, 32'h0);
        rd_chk("R1 init reset", 2'd2, 32'h0);
        rd_chk("R1 current reset", 2'd3, 32'h0);
        check("R1 irq low", 32'(irq_valid), 32'h0);

        // R3 R4 one-shot, shift 0
        wr(2'd0, 32'h0000_0041);
        rd_chk("R2 lvt readback", 2'd0, 32'h0000_0041);
        wr(2'd2, 32'd5);
        l = cyc;
        expect_irq(l + 6, 8'h41);
        wait_until(l + 3);
        rd_chk("R4 one-shot current", 2'd3, 32'd2);
        wait_until(l + 20);
        rd_chk("R4 one-shot after expiry", 2'd3, 32'd0);
        queue_empty("R3 single expiry");

        // R5 R6 periodic, divide code 0 -> /2
        wr(2'd1, 32'h0);
        wr(2'd0, 32'h0002_0052);
        wr(2'd2, 32'd3);
        l = cyc;
        expect_irq(l + 8, 8'h52);
        expect_irq(l + 16, 8'h52);
        expect_irq(l + 24, 8'h52);
        wait_until(l + 11);
        rd_chk("R6 periodic modulo current", 2'd3, 32'd2);
        wait_until(l + 26);
        wr(2'd2, 32'd0);
        queue_empty("R5 periodic expiries");

        // R7 zero count in periodic mode
        wr(2'd0, 32'h0002_0055);
        wr(2'd2, 32'd0);
        l = cyc;
        wait_until(l + 40);
        rd_chk("R7 zero count current", 2'd3, 32'd0);
        queue_empty("R7 no expiry");

        // R8 masked periodic, divide code 7 -> /1
        wr(2'd1, 32'h0000_000B);
        wr(2'd0, 32'h0003_0060);
        wr(2'd2, 32'd2);
        l = cyc;
        wait_until(l + 7);
        rd_chk("R8 masked still counts", 2'd3, 32'd1);
        wait_until(l + 30);
        queue_empty("R8 masked no irq");
        wr(2'd2, 32'd0);

        // R10 divide write does not restart
        wr(2'd0, 32'h0002_0070);
        rd_chk("R2 periodic lvt readback", 2'd0, 32'h0002_0070);
        wr(2'd2, 32'd100);
        l = cyc;
        wait_until(l + 10);
        wr(2'd1, 32'h0000_000B);
        rd_chk("R2 divide readback", 2'd1, 32'h0000_000B);
        rd_chk("R10 no restart on divide", 2'd3, 32'd89);
        wr(2'd2, 32'd0);

        // R9 reload in the same cycle as an expiry
        wr(2'd0, 32'h0002_0033);
        wr(2'd2, 32'd4);
        l = cyc;
        wait_until(l + 4);
        wr(2'd2, 32'd6);
        l2 = cyc;
        check("R9 reload edge", 32'(l2), 32'(l + 5));
        rd_chk("R9 restart value", 2'd3, 32'd6);
        expect_irq(l2 + 7, 8'h33);
        expect_irq(l2 + 14, 8'h33);
        wait_until(l2 + 16);
        wr(2'd2, 32'd0);
        repeat (5) @(negedge clk);
        queue_empty("R9 expiries after reload");

        report();
    end
endmodule